// File: doc/BRIEF.md
# TMDS Delay-Tap and Bitslip Alignment Controller

One instance of this controller serves one TMDS data lane. It runs in the recovered pixel-clock domain and watches the 10-bit words coming out of the deserializer. It steers an incrementing delay line through a tap-increment pulse and a tap-reset pulse, and it mirrors the commanded tap on an output. It also steers the deserializer's word boundary through a bitslip pulse. The controller probes every tap in turn. A tap is rated good when a run of control tokens appears within a time budget. The controller records runs of good taps as candidate eyes, and a run that touches either end of the tap range is judged by a stricter length rule.

When a valid eye is found, the controller rewinds the delay line, steps it to the centre of the eye and raises `aligned`. If a complete sweep yields no eye, it shifts the word boundary by one bitslip and sweeps again. A persistent failure raises `align_err` while retries continue. Losing the recovered-clock lock cancels everything, and alignment restarts when lock returns.

Top module: `tmds_eye_align`

## Requirements
- R1: While `rst` is high or `clk_locked` is low, `aligned`, `align_err`, `tap_inc`, `tap_rst` and `bitslip` are 0 and `tap_cur` is 0.
- R2: A tap is rated good only if RUN_LEN consecutive words each equal one of the control tokens 10'b1101010100, 10'b0010101011, 10'b0101010100 or 10'b1010101011 within TIMEOUT probe cycles. Otherwise it is rated bad, so shorter token runs never count.
- R3: Taps are probed in ascending order from 0. Each step is one `tap_inc` pulse that raises `tap_cur` by exactly one, and the sweep never steps beyond tap TAPS-1.
- R4: A run of good taps with a bad tap on each side is a valid eye when it is at least MIN_EYE (3) taps long. Shorter bounded runs are skipped.
- R5: A run of good taps that includes tap 0 or tap TAPS-1 is a valid eye only when it is at least EDGE_EYE (16) taps long.
- R6: The first valid eye met in sweep order is chosen. The controller pulses `tap_rst`, then steps `tap_cur` to floor((first+last)/2) of that eye, then raises `aligned`.
- R7: When tap TAPS-1 has been probed without a valid eye, one `bitslip` pulse is issued together with `tap_rst`, and the sweep restarts at tap 0.
- R8: `align_err` rises with the SLIP_LIMIT-th (10th) consecutive failed sweep. Retrying goes on, and the flag clears when alignment is achieved.
- R9: While `aligned` is high, no `tap_inc`, `tap_rst` or `bitslip` pulse is issued and `tap_cur` stays constant.
- R10: When `clk_locked` falls, `aligned` is low from the next cycle on. When lock returns, the sweep restarts from tap 0 without rewinding earlier bitslips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_locked | input | 1 | Recovered clock is locked; low forces a restart |
| word_in | input | 10 | Deserialized word of this lane |
| tap_inc | output | 1 | One-cycle pulse: advance the delay line by one tap |
| tap_rst | output | 1 | One-cycle pulse: return the delay line to tap 0 |
| tap_cur | output | $clog2(TAPS) (5) | Tap the delay line is commanded to |
| bitslip | output | 1 | One-cycle pulse: shift the deserializer word boundary |
| aligned | output | 1 | Lane sampled at the centre of a valid eye |
| align_err | output | 1 | SLIP_LIMIT consecutive sweeps found no eye |

## Verification
The assertions rely on the delay line and deserializer obeying every pulse within the SETTLE window. They also rely on `clk_locked` being meaningful only while reset is released, and on a jitter-zone tap never producing two control tokens back to back. The bench models the delay line as a tap counter that follows `tap_rst` and `tap_inc`, and it models the deserializer as a slip counter modulo 10. Clean token bursts are delivered only when the modelled tap lies inside the scenario's eye mask and the slip count equals the target. Outside that, data words are non-tokens, with isolated single tokens inserted at random to imitate the jitter zone.

// File: rtl/tea_pkg.sv
package tea_pkg;

   localparam int WORD_W = 10;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETTLE,
      ST_PROBE,
      ST_SEEK,
      ST_LOCK
   } align_state_t;

   // blanking-period control characters of a TMDS lane
   function automatic logic is_ctrl_token(input logic [WORD_W-1:0] w);
      return (w == 10'b1101010100) || (w == 10'b0010101011) ||
             (w == 10'b0101010100) || (w == 10'b1010101011);
   endfunction

endpackage

// File: rtl/tea_tap_probe.sv
module tea_tap_probe
   import tea_pkg::*;
#(
   parameter int TIMEOUT = 65536,
   parameter int RUN_LEN = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              enable,
   input  logic [WORD_W-1:0] word,
   output logic              done,
   output logic              good
);
   localparam int CW = $clog2(TIMEOUT);
   localparam int RW = $clog2(RUN_LEN + 1);

   generate
      if (RUN_LEN < 1 || TIMEOUT <= RUN_LEN) begin : g_bad_cfg
         $error("tea_tap_probe: TIMEOUT must exceed RUN_LEN >= 1");
      end
   endgenerate

   logic          tok_q;
   logic [CW-1:0] cyc;
   logic [RW-1:0] run;
   logic          run_full;

   assign run_full = tok_q && (run == RW'(RUN_LEN - 1));

   always_ff @(posedge clk) begin
      if (rst) tok_q <= 1'b0;
      else     tok_q <= is_ctrl_token(word);
   end

   always_ff @(posedge clk) begin
      if (rst || !enable) begin
         cyc  <= '0;
         run  <= '0;
         done <= 1'b0;
         good <= 1'b0;
      end else begin
         done <= 1'b0;
         good <= 1'b0;
         if (!done) begin
            cyc <= cyc + 1'b1;
            run <= tok_q ? run + 1'b1 : '0;
            if (run_full) begin
               done <= 1'b1;
               good <= 1'b1;
            end else if (cyc == CW'(TIMEOUT - 1)) begin
               done <= 1'b1;
            end
         end
      end
   end

   // R2: a verdict is a single-cycle strobe, and a good rating comes with it
   p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst) done |=> !done);
   p_good_done_r2:  assert property (@(posedge clk) disable iff (rst) good |-> done);

endmodule

// File: rtl/tea_eye_track.sv
module tea_eye_track #(
   parameter int TAPS     = 32,
   parameter int MIN_EYE  = 3,
   parameter int EDGE_EYE = 16,
   localparam int TW = $clog2(TAPS),
   localparam int LW = $clog2(TAPS + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          clear,
   input  logic          valid,
   input  logic          good,
   input  logic [TW-1:0] tap,
   output logic          hit,
   output logic [TW-1:0] centre
);
   generate
      if (MIN_EYE < 1 || MIN_EYE > EDGE_EYE || EDGE_EYE > TAPS) begin : g_bad_cfg
         $error("tea_eye_track: need 1 <= MIN_EYE <= EDGE_EYE <= TAPS");
      end
   endgenerate

   logic [TW-1:0] run_start, start_new;
   logic [LW-1:0] run_len, len_new;

   assign len_new   = run_len + 1'b1;
   assign start_new = (run_len == '0) ? tap : run_start;

   always_comb begin
      hit    = 1'b0;
      centre = '0;
      if (valid && good && tap == TW'(TAPS - 1)) begin
         // run reaches the top of the range: one boundary only
         hit    = len_new >= LW'(EDGE_EYE);
         centre = start_new + TW'((len_new - 1'b1) >> 1);
      end else if (valid && !good && run_len != '0) begin
         hit    = (run_start == '0) ? (run_len >= LW'(EDGE_EYE))
                                    : (run_len >= LW'(MIN_EYE));
         centre = run_start + TW'((run_len - 1'b1) >> 1);
      end
   end

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         run_start <= '0;
         run_len   <= '0;
      end else if (valid) begin
         if (good) begin
            run_start <= start_new;
            run_len   <= len_new;
         end else begin
            run_len <= '0;
         end
      end
   end

   p_len_bound_r4:  assert property (@(posedge clk) disable iff (rst) run_len <= LW'(TAPS));
   p_hit_strobe_r5: assert property (@(posedge clk) disable iff (rst) hit |-> valid);
   p_clear_r7:      assert property (@(posedge clk) disable iff (rst) clear |=> run_len == '0);

endmodule

// File: rtl/tmds_eye_align.sv
module tmds_eye_align
   import tea_pkg::*;
#(
   parameter int TAPS       = 32,
   parameter int TIMEOUT    = 65536,
   parameter int RUN_LEN    = 8,
   parameter int MIN_EYE    = 3,
   parameter int EDGE_EYE   = 16,
   parameter int SLIP_LIMIT = 10,
   parameter int SETTLE     = 4,
   localparam int TW = $clog2(TAPS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clk_locked,
   input  logic [WORD_W-1:0] word_in,
   output logic              tap_inc,
   output logic              tap_rst,
   output logic [TW-1:0]     tap_cur,
   output logic              bitslip,
   output logic              aligned,
   output logic              align_err
);
   localparam int SW = $clog2(SLIP_LIMIT + 1);
   localparam int CW = $clog2(SETTLE + 1);
   localparam logic [TW-1:0] LAST_TAP = TW'(TAPS - 1);

   generate
      if (TAPS < 2 || (1 << TW) != TAPS) begin : g_bad_taps
         $error("tmds_eye_align: TAPS must be a power of two >= 2");
      end
      if (SLIP_LIMIT < 1 || SETTLE < 1) begin : g_bad_limits
         $error("tmds_eye_align: SLIP_LIMIT and SETTLE must be >= 1");
      end
   endgenerate

   align_state_t  state;
   logic [CW-1:0] settle_cnt;
   logic [SW-1:0] fails;
   logic [TW-1:0] centre_r;

   logic          probe_en, probe_done, probe_good;
   logic          eye_hit, eye_clear, slip_now;
   logic [TW-1:0] eye_centre;

   assign probe_en  = (state == ST_PROBE);
   assign slip_now  = probe_en && probe_done && !eye_hit && (tap_cur == LAST_TAP);
   assign eye_clear = (state == ST_IDLE) || slip_now;

   tea_tap_probe #(.TIMEOUT(TIMEOUT), .RUN_LEN(RUN_LEN)) probe_i (
      .clk(clk), .rst(rst), .enable(probe_en), .word(word_in),
      .done(probe_done), .good(probe_good)
   );

   tea_eye_track #(.TAPS(TAPS), .MIN_EYE(MIN_EYE), .EDGE_EYE(EDGE_EYE)) eye_i (
      .clk(clk), .rst(rst), .clear(eye_clear),
      .valid(probe_en && probe_done), .good(probe_good), .tap(tap_cur),
      .hit(eye_hit), .centre(eye_centre)
   );

   always_ff @(posedge clk) begin
      if (rst || !clk_locked) begin
         state      <= ST_IDLE;
         settle_cnt <= '0;
         fails      <= '0;
         centre_r   <= '0;
         tap_cur    <= '0;
         tap_inc    <= 1'b0;
         tap_rst    <= 1'b0;
         bitslip    <= 1'b0;
         aligned    <= 1'b0;
         align_err  <= 1'b0;
      end else begin
         tap_inc <= 1'b0;
         tap_rst <= 1'b0;
         bitslip <= 1'b0;
         case (state)
            ST_IDLE: begin
               tap_rst    <= 1'b1;
               tap_cur    <= '0;
               settle_cnt <= '0;
               state      <= ST_SETTLE;
            end
            ST_SETTLE: begin
               settle_cnt <= settle_cnt + 1'b1;
               if (settle_cnt == CW'(SETTLE - 1)) begin
                  settle_cnt <= '0;
                  state      <= ST_PROBE;
               end
            end
            ST_PROBE: begin
               if (probe_done) begin
                  if (eye_hit) begin
                     centre_r <= eye_centre;
                     tap_rst  <= 1'b1;
                     tap_cur  <= '0;
                     state    <= ST_SEEK;
                  end else if (tap_cur == LAST_TAP) begin
                     bitslip <= 1'b1;
                     tap_rst <= 1'b1;
                     tap_cur <= '0;
                     if (fails != SW'(SLIP_LIMIT)) fails <= fails + 1'b1;
                     if (fails >= SW'(SLIP_LIMIT - 1)) align_err <= 1'b1;
                     state <= ST_SETTLE;
                  end else begin
                     tap_inc <= 1'b1;
                     tap_cur <= tap_cur + 1'b1;
                     state   <= ST_SETTLE;
                  end
               end
            end
            ST_SEEK: begin
               if (tap_cur == centre_r) begin
                  aligned   <= 1'b1;
                  align_err <= 1'b0;
                  fails     <= '0;
                  state     <= ST_LOCK;
               end else begin
                  tap_inc <= 1'b1;
                  tap_cur <= tap_cur + 1'b1;
               end
            end
            default: state <= ST_LOCK;
         endcase
      end
   end

   // R3: a step never wraps the tap and never coincides with a rewind or a slip
   p_no_wrap_r3:    assert property (@(posedge clk) disable iff (rst) tap_inc |-> tap_cur != '0);
   p_step_excl_r3:  assert property (@(posedge clk) disable iff (rst) tap_inc |-> !tap_rst && !bitslip);
   // R7: every slip also rewinds the delay line
   p_slip_rewind_r7: assert property (@(posedge clk) disable iff (rst) bitslip |-> tap_rst && tap_cur == '0);
   // R8: the error flag only rises together with a slip
   p_err_slip_r8:   assert property (@(posedge clk) disable iff (rst) $rose(align_err) |-> bitslip);
   // R9: steady outputs once aligned
   p_hold_r9: assert property (@(posedge clk) disable iff (rst)
      aligned && $past(aligned) |-> !tap_inc && !tap_rst && !bitslip && $stable(tap_cur));
   // R10: lock loss cancels alignment on the next edge
   p_unlock_r10:    assert property (@(posedge clk) disable iff (rst) !clk_locked |=> !aligned);

endmodule

// File: tb/tmds_eye_align_tb_top.sv
module tmds_eye_align_tb_top;
   localparam int TAPS = 32;
   localparam int TO   = 64;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       clk_locked = 1'b1;
   logic [9:0] word_in = '0;
   logic       tap_inc, tap_rst, bitslip, aligned, align_err;
   logic [4:0] tap_cur;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   // delay-line and deserializer model state
   int          tap_m = 0;
   int          slip_m = 0;
   logic [31:0] mask = '0;
   int          target = 0;
   bit          short_runs = 0;
   bit          prev_tok = 0;
   int          phase = 0;
   int          step_viol = 0;
   int          prev_cur = 0;

   always #10 clk = ~clk;

   tmds_eye_align #(.TAPS(TAPS), .TIMEOUT(TO)) dut_i (
      .clk(clk), .rst(rst), .clk_locked(clk_locked), .word_in(word_in),
      .tap_inc(tap_inc), .tap_rst(tap_rst), .tap_cur(tap_cur),
      .bitslip(bitslip), .aligned(aligned), .align_err(align_err)
   );

   function automatic bit is_tok(logic [9:0] w);
      return (w == 10'b1101010100) || (w == 10'b0010101011) ||
             (w == 10'b0101010100) || (w == 10'b1010101011);
   endfunction

   function automatic logic [9:0] tok(int i);
      case (i % 4)
         0: return 10'b1101010100;
         1: return 10'b0010101011;
         2: return 10'b0101010100;
         default: return 10'b1010101011;
      endcase
   endfunction

   function automatic logic [9:0] nontok();
      logic [9:0] w = 10'($urandom);
      if (is_tok(w)) w = w ^ 10'd1;
      return w;
   endfunction

   // expected eye centre from the rules of R4/R5/R6, -1 if none
   function automatic int ref_centre(logic [31:0] m);
      int st = -1;
      for (int t = 0; t < TAPS; t++) begin
         if (m[t]) begin
            if (st < 0) st = t;
            if (t == TAPS - 1 && (TAPS - st) >= 16) return st + (TAPS - st - 1) / 2;
         end else if (st >= 0) begin
            if ((st == 0) ? (t - st >= 16) : (t - st >= 3)) return st + (t - st - 1) / 2;
            st = -1;
         end
      end
      return -1;
   endfunction

   // models of the delay line and the word-boundary shifter
   always @(posedge clk) begin
      if (rst) begin
         tap_m  <= 0;
         slip_m <= 0;
      end else begin
         if (tap_rst) tap_m <= 0;
         else if (tap_inc) tap_m <= tap_m + 1;
         if (bitslip) slip_m <= (slip_m + 1) % 10;
      end
   end

   // lane stream driven away from the active edge, plus an R3 step monitor
   always @(negedge clk) begin
      if (!rst && tap_inc && (int'(tap_cur) != prev_cur + 1 || prev_cur >= TAPS - 1))
         step_viol++;
      prev_cur = int'(tap_cur);
      if (mask[tap_m % TAPS] && slip_m == target) begin
         phase = (phase + 1) % (short_runs ? 10 : 40);
         word_in = (phase < (short_runs ? 7 : 24)) ? tok($urandom) : nontok();
      end else if (!prev_tok && ($urandom % 8) == 0) begin
         word_in = tok($urandom);
      end else begin
         word_in = nontok();
      end
      prev_tok = is_tok(word_in);
   end

   task automatic check(bit ok, string req, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic wait_aligned(int limit, string req);
      int n = 0;
      while (!aligned && n < limit) begin
         @(negedge clk);
         n++;
      end
      check(aligned == 1'b1, req, int'(aligned), 1);
   endtask

   task automatic run_case(logic [31:0] m, int tgt, string req);
      int exp = ref_centre(m);
      mask = m;
      target = tgt;
      do_reset();
      wait_aligned(40000, req);
      check(int'(tap_cur) == exp, req, int'(tap_cur), exp);
      check(tap_m == exp, req, tap_m, exp);
      check(slip_m == tgt, "R7 slip count", slip_m, tgt);
      repeat (20) @(negedge clk);
      check(aligned && int'(tap_cur) == exp && tap_m == exp, "R9 hold", int'(tap_cur), exp);
   endtask

   initial begin
      void'($urandom(32'd2024));
      repeat (2) @(negedge clk);
      // R1: reset state
      check(!aligned && !align_err && !tap_inc && !tap_rst && !bitslip && tap_cur == 0,
            "R1 reset", int'({aligned, align_err, tap_inc, tap_rst, bitslip}), 0);

      run_case(32'h0001_FC00, 0, "R4 interior eye 10..16");
      run_case(32'h0000_03E0, 3, "R7 eye after 3 slips");
      run_case(32'h0003_FFFF, 0, "R5 left-edge eye 0..17");
      run_case(32'hFFFF_C000, 1, "R5 right-edge eye 14..31");
      run_case(32'hFFFF_FFFF, 0, "R6 all taps good");
      run_case(32'h00F0_003F, 0, "R5 short left edge skipped");
      run_case(32'h0000_7030, 0, "R4 two-tap run skipped");

      // R5: short run at the top edge is no eye, a slip follows
      mask = 32'hFC00_0000; target = 0;
      do_reset();
      repeat (2600) @(negedge clk);
      check(!aligned && slip_m == 1, "R5 short right edge", slip_m, 1);

      // R2: token runs one short of RUN_LEN never rate a tap good
      mask = 32'h0001_FC00; short_runs = 1;
      do_reset();
      repeat (2600) @(negedge clk);
      check(!aligned && slip_m == 1, "R2 short token runs", slip_m, 1);
      short_runs = 0;

      // randomized interior eyes
      for (int i = 0; i < 6; i++) begin
         int st = 1 + int'($urandom % 20);
         int ln = 3 + int'($urandom % 8);
         logic [31:0] m = '0;
         for (int k = 0; k < ln; k++) m[st + k] = 1'b1;
         run_case(m, int'($urandom % 3), "R6 random eye");
      end

      // R8: error after ten failed sweeps, retries continue, clears on success
      mask = '0; target = 0;
      do_reset();
      begin
         int n = 0;
         while (!align_err && n < 30000) begin
            @(negedge clk);
            n++;
         end
      end
      check(align_err == 1'b1, "R8 error raised", int'(align_err), 1);
      @(negedge clk);
      check(slip_m == 0 && !aligned, "R8 ten slips (mod 10)", slip_m, 0);
      mask = 32'h0001_FC00;
      wait_aligned(40000, "R8 retry aligns");
      check(align_err == 1'b0 && int'(tap_cur) == 13, "R8 error cleared", int'(align_err), 0);

      // R10: loss of lock and realignment
      run_case(32'h0001_FC00, 2, "R10 pre-unlock align");
      clk_locked = 1'b0;
      @(negedge clk);
      check(!aligned, "R10 unlock drops aligned", int'(aligned), 0);
      repeat (4) @(negedge clk);
      check(tap_cur == 0 && !tap_inc && !bitslip, "R1 idle while unlocked", int'(tap_cur), 0);
      clk_locked = 1'b1;
      wait_aligned(40000, "R10 realign");
      check(int'(tap_cur) == 13 && slip_m == 2, "R10 realign centre, slips kept", int'(tap_cur), 13);

      check(step_viol == 0, "R3 single ascending steps", step_viol, 0);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (195000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog R6 actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule